// File: doc/BRIEF.md
# Fault-Secure Triple Five-Way Voter

This block votes across five redundant copies of a datapath and delivers the result in a form whose corruption can always be seen. Three independent five-way voters receive the same module outputs and the same repair controls. Every data bit leaves the block as a three-bit group, one bit from each voter copy. A group of 000 or 111 is a valid codeword. Any other group means the voting logic itself has been upset. A single or a double upset that hits the voter copies can therefore turn a group into a non-codeword, but never into the other valid codeword.

Each voter copy keeps one exclusion flag per module. A module whose output disagrees with the copy's vote is dropped from later votes. The repair side can reinstate it once it agrees again. When no module is excluded, the copy takes a plain majority of all five. Otherwise it takes a three-input majority over the three lowest-numbered modules still in service.

A decoder inside the block reduces the groups to a data word for consumers that cannot take the coded form. It also raises an error flag, which stays set until it is acknowledged.

Top module: `tmv_secure_voter`

## Requirements
- R1: With no module excluded, each voted bit is the majority of the five module bits. Identical module inputs always vote to that common value.
- R2: A module whose word differs from the copy's vote in any bit is excluded from the next clock edge on. While at least three modules remain in service, the vote is the majority of the three lowest-indexed modules still in service.
- R3: When fewer than three modules remain in service, the vote falls back to the majority of all five module bits.
- R4: A rearm pulse clears a module's exclusion at the next edge only if that module agrees with the vote in that cycle. Otherwise the pulse has no effect.
- R5: Data bit b is carried on `code_o[3b+2:3b]`, with copy k at position 3b+k. In fault-free operation every group is 000 or 111 and equals the voted bit.
- R6: A flip or a stuck value on one voter copy, or an identical corruption on two copies, never produces a valid codeword that differs from the fault-free vote. Each affected bit shows a non-codeword.
- R7: `err_o` rises at the edge after any group is a non-codeword. It stays set until `ack_i` is high in a cycle in which every group is valid. An acknowledge during an invalid cycle is ignored.
- R8: `data_o` loads the decoded word at each edge where all groups are valid, taking bit b from `code_o[3b]`. It holds its last value at any edge where some group is invalid.
- R9: The reset is synchronous and active low. It clears all exclusion flags, `data_o` and `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_i | input | N_MOD*WIDTH | Module outputs; module i at bits [i*WIDTH +: WIDTH] |
| rearm_i | input | N_MOD | Per-module request to return a repaired module to the vote |
| ack_i | input | 1 | Clears the sticky error flag when all groups are valid |
| code_o | output | 3*WIDTH | Coded result: three bits per data bit, one per voter copy |
| data_o | output | WIDTH | Registered decoded word, held while the code is invalid |
| err_o | output | 1 | Sticky flag: a non-codeword has been seen |

## Verification
On every cycle, the assertions check four things: the unanimous vote, that a disagreeing module is excluded at the next edge, that an agreeing rearm reinstates it, and that the error flag, the load and the hold of the decoded word follow the agreement of the three copies. Some behaviour is visible only through the bench's scenarios, which corrupt voter copies from outside. These scenarios show that the exclusion state steers the vote between the lowest-three selection and the five-way fallback. They also show that an ignored rearm leaves the module out of the vote, and that no single or double copy corruption ever yields a wrong valid codeword.

// File: rtl/tmv_pkg.sv
// Package: shared constants and the codeword test for the coded voter output.
// Assumes exactly three voter copies; the code is repetition of each bit.
package tmv_pkg;

    // Number of voter copies that form one coded group.
    localparam int unsigned COPIES = 3;

    // A group is a codeword only when all three copy bits agree.
    function automatic logic group_is_code(input logic [COPIES-1:0] grp);
        return (grp == {COPIES{1'b0}}) || (grp == {COPIES{1'b1}});
    endfunction

endpackage

// File: rtl/tmv_voter_copy.sv
// Module: one five-way voter copy with per-module exclusion flags.
// Does: votes WIDTH bits across N_MOD modules. With no exclusion it takes the
// full majority; otherwise it takes a three-way majority over the three
// lowest-indexed modules in service, and it falls back to the full majority
// when fewer than three remain. A disagreeing module is excluded at the next
// edge. A rearm returns it only while it agrees with the vote.
// Assumes: N_MOD >= 3 and odd, so the full majority is never a tie.
module tmv_voter_copy #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned N_MOD = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_MOD*WIDTH-1:0]   mod_i,
    input  logic [N_MOD-1:0]         rearm_i,
    output logic [WIDTH-1:0]         vote_o
);

    localparam int unsigned     CNT_W = $clog2(N_MOD + 1);
    localparam logic [CNT_W-1:0] HALF  = CNT_W'(N_MOD / 2);
    localparam logic [CNT_W-1:0] MIN3  = CNT_W'(3);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic [N_MOD-1:0]  excl_q;
    logic [N_MOD-1:0]  pick;
    logic [N_MOD-1:0]  mism;
    logic [CNT_W-1:0]  active_cnt;
    logic              use_all;

    // Mark the three lowest-indexed modules still in service.
    always_comb begin : pick_lowest_three
        logic [1:0] taken;
        taken = 2'd0;
        pick  = '0;
        for (int i = 0; i < N_MOD; i++) begin
            if (!excl_q[i] && taken != 2'd3) begin
                pick[i] = 1'b1;
                taken   = taken + 2'd1;
            end
        end
    end

    // Count modules in service and choose between the full and the reduced vote.
    always_comb begin : select_mode
        active_cnt = '0;
        for (int i = 0; i < N_MOD; i++) begin
            if (!excl_q[i]) active_cnt = active_cnt + ONE;
        end
        use_all = (excl_q == '0) || (active_cnt < MIN3);
    end

    // Per-bit majority, either full or over the picked three.
    always_comb begin : vote_bits
        logic [CNT_W-1:0] n_all;
        logic [1:0]       n_pick;
        vote_o = '0;
        for (int b = 0; b < WIDTH; b++) begin
            n_all  = '0;
            n_pick = 2'd0;
            for (int i = 0; i < N_MOD; i++) begin
                if (mod_i[i*WIDTH + b]) n_all = n_all + ONE;
                if (mod_i[i*WIDTH + b] && pick[i]) n_pick = n_pick + 2'd1;
            end
            vote_o[b] = use_all ? (n_all > HALF) : (n_pick >= 2'd2);
        end
    end

    // Flag each module whose word differs from the vote in any bit.
    always_comb begin : find_mismatch
        for (int i = 0; i < N_MOD; i++) begin
            mism[i] = |(mod_i[i*WIDTH +: WIDTH] ^ vote_o);
        end
    end

    // Exclusion flags: set on mismatch, cleared by rearm only when agreeing.
    always_ff @(posedge clk) begin : excl_reg
        if (!rst_n) begin
            excl_q <= '0;
        end else begin
            for (int i = 0; i < N_MOD; i++) begin
                if (mism[i])         excl_q[i] <= 1'b1;
                else if (rearm_i[i]) excl_q[i] <= 1'b0;
            end
        end
    end

    // Unanimity detector used only by the assertion below.
    logic all_same;
    always_comb begin : unanimity
        all_same = 1'b1;
        for (int i = 1; i < N_MOD; i++) begin
            if (mod_i[i*WIDTH +: WIDTH] != mod_i[WIDTH-1:0]) all_same = 1'b0;
        end
    end

    a_r1_unanimous_vote: assert property (@(posedge clk) disable iff (!rst_n)
        all_same |-> (vote_o == mod_i[WIDTH-1:0]));

    for (genvar i = 0; i < N_MOD; i++) begin : g_excl_chk
        a_r2_exclude_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
            (mod_i[i*WIDTH +: WIDTH] != vote_o) |=> excl_q[i]);
        a_r4_rearm_when_agreeing: assert property (@(posedge clk) disable iff (!rst_n)
            (rearm_i[i] && (mod_i[i*WIDTH +: WIDTH] == vote_o)) |=> !excl_q[i]);
    end

endmodule

// File: rtl/tmv_code_check.sv
// Module: decoder for the coded voter output.
// Does: flags any group that is not 000/111. It loads the decoded word from
// copy 0 when every group is valid and holds the word otherwise. It keeps a
// sticky error flag that an acknowledge clears only in a fully valid cycle.
// Assumes: code_i groups laid out as bit b at [3b+2:3b], copy k at 3b+k.
module tmv_code_check #(
    parameter int unsigned WIDTH = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [tmv_pkg::COPIES*WIDTH-1:0]     code_i,
    input  logic                                 ack_i,
    output logic [WIDTH-1:0]                     data_o,
    output logic                                 err_o
);

    localparam int unsigned G = tmv_pkg::COPIES;

    logic [WIDTH-1:0] bad;
    logic [WIDTH-1:0] head;
    logic             any_bad;

    // Classify each group and pick the copy-0 bit as the decoded value.
    always_comb begin : classify
        for (int b = 0; b < WIDTH; b++) begin
            bad[b]  = !tmv_pkg::group_is_code(code_i[b*G +: G]);
            head[b] = code_i[b*G];
        end
        any_bad = |bad;
    end

    // Decoded word: load on a fully valid cycle, hold otherwise.
    always_ff @(posedge clk) begin : data_reg
        if (!rst_n)        data_o <= '0;
        else if (!any_bad) data_o <= head;
    end

    // Sticky error flag; a new fault wins over the acknowledge.
    always_ff @(posedge clk) begin : err_reg
        if (!rst_n)       err_o <= 1'b0;
        else if (any_bad) err_o <= 1'b1;
        else if (ack_i)   err_o <= 1'b0;
    end

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !ack_i) |=> err_o);

endmodule

// File: rtl/tmv_secure_voter.sv
// Module: top of the fault-secure voter.
// Does: runs three independent five-way voter copies on the same inputs and
// interleaves their outputs into a three-bit group per data bit. It decodes
// the groups into a held data word and a sticky error flag.
// Assumes: the copies share no state; placement of the copies is external.
module tmv_secure_voter #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned N_MOD = 5
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [N_MOD*WIDTH-1:0]               mod_i,
    input  logic [N_MOD-1:0]                     rearm_i,
    input  logic                                 ack_i,
    output logic [tmv_pkg::COPIES*WIDTH-1:0]     code_o,
    output logic [WIDTH-1:0]                     data_o,
    output logic                                 err_o
);

    localparam int unsigned G = tmv_pkg::COPIES;

    logic [WIDTH-1:0] copy_vote [G];

    // Three independent voter copies, each with its own exclusion state.
    for (genvar k = 0; k < G; k++) begin : g_copy
        wire [WIDTH-1:0] vote_w;
        tmv_voter_copy #(.WIDTH(WIDTH), .N_MOD(N_MOD)) u_voter (
            .clk     (clk),
            .rst_n   (rst_n),
            .mod_i   (mod_i),
            .rearm_i (rearm_i),
            .vote_o  (vote_w)
        );
        assign copy_vote[k] = vote_w;
    end

    // Interleave copy bits into one group per data bit.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        for (genvar k = 0; k < G; k++) begin : g_pos
            assign code_o[b*G + k] = copy_vote[k][b];
        end
    end

    tmv_code_check #(.WIDTH(WIDTH)) u_check (
        .clk    (clk),
        .rst_n  (rst_n),
        .code_i (code_o),
        .ack_i  (ack_i),
        .data_o (data_o),
        .err_o  (err_o)
    );

    // Copy disagreement, seen by the assertions only.
    logic split;
    assign split = (copy_vote[0] != copy_vote[1]) || (copy_vote[1] != copy_vote[2]);

    a_r7_flag_on_split: assert property (@(posedge clk) disable iff (!rst_n)
        split |=> err_o);
    a_r8_hold_on_split: assert property (@(posedge clk) disable iff (!rst_n)
        split |=> $stable(data_o));
    a_r8_load_on_agree: assert property (@(posedge clk) disable iff (!rst_n)
        !split |=> (data_o == $past(copy_vote[0])));

endmodule

// File: tb/tmv_secure_voter_test.sv
`timescale 1ns/1ps
module tmv_secure_voter_test;

    localparam int W = 8;
    localparam int N = 5;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [N*W-1:0] mod_i;
    logic [N-1:0]   rearm_i;
    logic           ack_i;
    logic [3*W-1:0] code_o;
    logic [W-1:0]   data_o;
    logic           err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] inj0, inj1, inj2;

    always #2 clk = ~clk;   // 250 MHz

    tmv_secure_voter #(.WIDTH(W), .N_MOD(N)) uut (
        .clk(clk), .rst_n(rst_n), .mod_i(mod_i), .rearm_i(rearm_i),
        .ack_i(ack_i), .code_o(code_o), .data_o(data_o), .err_o(err_o)
    );

    function automatic logic [3*W-1:0] grp(input logic [W-1:0] a, b, c);
        logic [3*W-1:0] r;
        for (int i = 0; i < W; i++) begin
            r[3*i]     = a[i];
            r[3*i + 1] = b[i];
            r[3*i + 2] = c[i];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // No group may be a valid codeword that differs from the clean vote.
    task automatic check_secure(input string req, input logic [W-1:0] clean);
        int wrong = 0;
        checks++;
        for (int b = 0; b < W; b++) begin
            if ((code_o[3*b +: 3] == 3'b111 && !clean[b]) ||
                (code_o[3*b +: 3] == 3'b000 &&  clean[b])) wrong++;
        end
        if (wrong != 0) begin
            fails++;
            $display("FAIL %s: actual %0d wrong codewords expected 0 (code %h)", req, wrong, code_o);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_mods(input logic [W-1:0] m0, m1, m2, m3, m4);
        mod_i = {m4, m3, m2, m1, m0};
    endtask

    task automatic settle_clean(input logic [W-1:0] v);
        set_mods(v, v, v, v, v);
        rearm_i = '1;
        tick();
        rearm_i = '0;
        tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; ack_i = 1'b0; rearm_i = '0;
        set_mods(8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A);
        tick(); tick(); tick();
        check("R9 data cleared in reset", 32'(data_o), 32'h0);
        check("R9 err cleared in reset", 32'(err_o), 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_majority();
        set_mods(8'hC3, 8'hC3, 8'hC3, 8'hC3, 8'hC3);
        #1 check("R5 unanimous code layout", 32'(code_o), 32'(grp(8'hC3, 8'hC3, 8'hC3)));
        tick();
        check("R8 data loads valid word", 32'(data_o), 32'hC3);
        check("R7 no error when clean", 32'(err_o), 32'h0);
        set_mods(8'h96, 8'h96, 8'h96, 8'h69, 8'h69);
        #1 check("R1 five-way majority 3 of 5", 32'(code_o), 32'(grp(8'h96, 8'h96, 8'h96)));
        tick();
        check("R1 data after majority", 32'(data_o), 32'h96);
        settle_clean(8'h96);
    endtask

    task automatic t_exclude();
        logic [W-1:0] a = 8'hA5;
        settle_clean(a);
        set_mods(a, a, ~a, a, a);
        #1 check("R1 one outlier outvoted", 32'(code_o), 32'(grp(a, a, a)));
        tick();   // module 2 now excluded
        set_mods(a, a, ~a, ~a, ~a);
        #1 check("R2 lowest three in service decide", 32'(code_o), 32'(grp(a, a, a)));
        tick();   // modules 3 and 4 also excluded
        check("R2 data from reduced vote", 32'(data_o), 32'(a));
        #1 check("R3 fallback to five-way majority", 32'(code_o), 32'(grp(~a, ~a, ~a)));
        settle_clean(a);
    endtask

    task automatic t_rearm();
        logic [W-1:0] a = 8'h3C;
        settle_clean(a);
        set_mods(a, a, ~a, a, a);
        tick();                 // module 2 excluded
        rearm_i = 5'b00100;
        tick();                 // rearm while still disagreeing: ignored
        rearm_i = '0;
        set_mods(a, a, ~a, ~a, ~a);
        #1 check("R4 rearm ignored while mismatching", 32'(code_o), 32'(grp(a, a, a)));
        tick();                 // modules 3 and 4 excluded as well
        set_mods(a, a, a, a, a);
        rearm_i = 5'b00100;
        tick();                 // module 2 agrees: returns to service
        rearm_i = '0;
        set_mods(a, ~a, ~a, a, a);
        #1 check("R4 rearmed module back in vote", 32'(code_o), 32'(grp(~a, ~a, ~a)));
        settle_clean(a);
    endtask

    task automatic t_single_fault();
        logic [W-1:0] a = 8'h5C;
        logic [W-1:0] b = 8'h3A;
        settle_clean(a);
        check("R7 clean before fault", 32'(err_o), 32'h0);
        inj1 = a ^ 8'h0F;
        force uut.g_copy[1].vote_w = inj1;
        #1 check("R5 corrupted copy shows in its position", 32'(code_o), 32'(grp(a, a ^ 8'h0F, a)));
        check_secure("R6 single flip", a);
        tick();
        check("R7 error raised after single flip", 32'(err_o), 32'h1);
        check("R8 data held during fault", 32'(data_o), 32'(a));
        inj1 = a;               // copy 1 stuck at old value
        set_mods(b, b, b, b, b);
        #1 check_secure("R6 single stuck copy", b);
        tick();
        check("R8 data held, inputs changed", 32'(data_o), 32'(a));
        release uut.g_copy[1].vote_w;
        settle_clean(b);
        check("R8 data reloads after release", 32'(data_o), 32'(b));
        check("R7 error stays without ack", 32'(err_o), 32'h1);
    endtask

    task automatic t_double_fault();
        logic [W-1:0] a = 8'hE1;
        settle_clean(a);
        inj0 = a ^ 8'hF0;
        inj2 = a ^ 8'hF0;
        force uut.g_copy[0].vote_w = inj0;
        force uut.g_copy[2].vote_w = inj2;
        #1 check_secure("R6 identical double flip", a);
        check("R6 double flip code", 32'(code_o), 32'(grp(a ^ 8'hF0, a, a ^ 8'hF0)));
        inj0 = 8'hFF;
        inj2 = 8'h00;
        #1 check_secure("R6 double stuck copies", a);
        release uut.g_copy[0].vote_w;
        release uut.g_copy[2].vote_w;
        inj1 = 8'hFF;
        inj2 = 8'hFF;
        force uut.g_copy[1].vote_w = inj1;
        force uut.g_copy[2].vote_w = inj2;
        #1 check_secure("R6 double stuck-at-one", a);
        tick();
        check("R7 error after double fault", 32'(err_o), 32'h1);
        check("R8 hold under double fault", 32'(data_o), 32'(a));
        release uut.g_copy[1].vote_w;
        release uut.g_copy[2].vote_w;
        settle_clean(a);
    endtask

    task automatic t_ack();
        logic [W-1:0] a = 8'h77;
        settle_clean(a);
        inj2 = a ^ 8'h01;
        force uut.g_copy[2].vote_w = inj2;
        ack_i = 1'b1;
        tick();
        check("R7 ack ignored while invalid", 32'(err_o), 32'h1);
        release uut.g_copy[2].vote_w;
        #1 tick();
        check("R7 ack clears when valid", 32'(err_o), 32'h0);
        ack_i = 1'b0;
        tick();
        check("R7 stays clear", 32'(err_o), 32'h0);
    endtask

    initial begin
        inj0 = '0; inj1 = '0; inj2 = '0;
        t_reset();
        t_majority();
        t_exclude();
        t_rearm();
        t_single_fault();
        t_double_fault();
        t_ack();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule